// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block is a lane-parallel multiply datapath for a vector execution pipe. It offers two operations on a pair of vector operands. In the fractional operation, each 16-bit lane of both operands is read as a signed Q15 value in [-1, 1). Each lane returns the rounded upper part of its product. In the byte multiply-add operation, each byte of the first operand is treated as unsigned and each byte of the second operand as signed. The two products in each adjacent byte pair are summed, and that sum is clamped into a signed 16-bit word lane.

A mode bit selects whether the full 128-bit vector is processed or only its low 64 bits. In 64-bit mode the upper half of the result reads as zero. The result is registered. A valid strobe on the input produces a valid strobe and result on the output exactly one clock later. The result register keeps its value between strobes.

Top module: `pfx_mul_unit`

## Requirements
- R1: `rst_ni` low asynchronously clears `valid_o` and `res_o` to zero. `valid_o` is high exactly in the cycle after a cycle in which `valid_i` was high, and `res_o` holds the result for that input in that cycle.
- R2: With `op_i` = 0 (fractional), each 16-bit lane k (bits [16k+15:16k]) of the result equals the low 16 bits of floor((a·b + 2^14) / 2^15), where a and b are the signed lane values of `a_i` and `b_i`. This is round to nearest with ties toward +infinity, not truncation.
- R3: In fractional mode, 0x8000 times 0x8000 yields 0x8000, 0x4000 times 0x4000 yields 0x2000, and 0xA000 times 0x4000 yields 0xD000.
- R4: With `op_i` = 1 (multiply-add), word lane k equals u(2k)·s(2k) + u(2k+1)·s(2k+1). Here byte j sits at bits [8j+7:8j], u(j) is byte j of `a_i` read unsigned, and s(j) is byte j of `b_i` read signed.
- R5: In multiply-add mode, a pair sum above 32767 gives 0x7FFF, a pair sum below -32768 gives 0x8000, and any other sum passes unchanged.
- R6: With `wide_i` = 1, all 128 result bits are computed. With `wide_i` = 0, only bits [63:0] are computed and `res_o[127:64]` is zero.
- R7: While `valid_i` is low, `res_o` keeps its previous value whatever `a_i`, `b_i`, `op_i` and `wide_i` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands valid |
| op_i | input | 1 | 0 = fractional rounded multiply, 1 = byte multiply-add |
| wide_i | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| a_i | input | 128 | First operand (unsigned bytes in multiply-add) |
| b_i | input | 128 | Second operand (signed bytes in multiply-add) |
| valid_o | output | 1 | Result valid, one clock after `valid_i` |
| res_o | output | 128 | Registered result vector |

## Verification
The bench sweeps every combination of one unsigned byte against one signed byte, paired with an extreme second product. A datapath that reads the first operand as signed, or that wraps instead of clamping, therefore gives visibly wrong words on both sides of the saturation limits. The fractional sweep and its corner vectors separate true rounding from truncation, which would be off by one on half the results. They also check that the negative-one-squared case wraps to 0x8000; a design that saturated or widened that case would fail. Narrow-mode vectors catch upper lanes that leak data, and idle cycles with changing operands catch a result register that loads without a strobe.

// File: rtl/pfx_mul_pkg.sv
package pfx_mul_pkg;
  typedef enum logic {
    OP_FRAC = 1'b0,
    OP_MADD = 1'b1
  } pfx_op_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pfx_frac_lane.sv
module pfx_frac_lane (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  output logic [15:0] r_o
);
  logic signed [31:0] prod;
  logic signed [17:0] scaled;

  assign prod   = $signed({{16{a_i[15]}}, a_i}) * $signed({{16{b_i[15]}}, b_i});
  // keep one guard bit below the result, add half an lsb, drop the guard
  assign scaled = $signed(prod[31:14]) + 18'sd1;
  assign r_o    = scaled[16:1];
endmodule

// File: rtl/pfx_madd_lane.sv
module pfx_madd_lane (
  input  logic [15:0] u_i,
  input  logic [15:0] s_i,
  output logic [15:0] r_o
);
  logic signed [17:0] p_lo, p_hi, sum;

  assign p_lo = $signed({10'd0, u_i[7:0]}) * $signed({{10{s_i[7]}}, s_i[7:0]});
  assign p_hi = $signed({10'd0, u_i[15:8]}) * $signed({{10{s_i[15]}}, s_i[15:8]});
  assign sum  = p_lo + p_hi;

  always_comb begin
    if (sum > 18'sd32767)       r_o = 16'h7fff;
    else if (sum < -18'sd32768) r_o = 16'h8000;
    else                        r_o = sum[15:0];
  end
endmodule

// File: rtl/pfx_mul_unit.sv
module pfx_mul_unit #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             op_i,
  input  logic             wide_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o
);
  import pfx_mul_pkg::*;

  localparam int unsigned LANES     = VEC_W / WORD_W;
  localparam int unsigned HALF_LANE = LANES / 2;

  logic [VEC_W-1:0] res_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] frac_r, madd_r;
    logic              lane_on;

    pfx_frac_lane u_frac (
      .a_i (a_i[g*WORD_W +: WORD_W]),
      .b_i (b_i[g*WORD_W +: WORD_W]),
      .r_o (frac_r)
    );

    pfx_madd_lane u_madd (
      .u_i (a_i[g*WORD_W +: WORD_W]),
      .s_i (b_i[g*WORD_W +: WORD_W]),
      .r_o (madd_r)
    );

    if (g < HALF_LANE) begin : g_low
      assign lane_on = 1'b1;
    end else begin : g_high
      assign lane_on = wide_i;
    end

    assign res_d[g*WORD_W +: WORD_W] = !lane_on           ? '0     :
                                       (op_i == OP_MADD)  ? madd_r : frac_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end
endmodule

// File: rtl/pfx_mul_unit_chk.sv
module pfx_mul_unit_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             op_i,
  input logic             wide_i,
  input logic [VEC_W-1:0] a_i,
  input logic [VEC_W-1:0] b_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] res_o
);
  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R7
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  // R6
  narrow_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> (res_o[VEC_W-1:VEC_W/2] == '0));
  // R3
  min_square_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i && a_i[15:0] == 16'h8000 && b_i[15:0] == 16'h8000)
      |=> (res_o[15:0] == 16'h8000));
  // R4
  madd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i && wide_i && b_i == '0) |=> (res_o == '0));
  // R5
  madd_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i && a_i[15:0] == 16'hffff && b_i[15:0] == 16'h7f7f)
      |=> (res_o[15:0] == 16'h7fff));
endmodule

bind pfx_mul_unit pfx_mul_unit_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/pfx_mul_unit_bench.sv
module pfx_mul_unit_bench;
  localparam int W = 128;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         op_i = 1'b0;
  logic         wide_i = 1'b1;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         valid_o;
  logic [W-1:0] res_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic         pend = 1'b0;
  logic [W-1:0] pend_exp;
  string        pend_tag;

  always #10 clk_i = ~clk_i;

  pfx_mul_unit u_pfx_mul_unit (.*);

  function automatic logic [15:0] frac_ref(logic [15:0] a, logic [15:0] b);
    longint n, q;
    n = longint'($signed(a)) * longint'($signed(b)) + 64'sd16384;
    q = n / 32768;
    if ((n % 32768) != 0 && n < 0) q = q - 1;
    return q[15:0];
  endfunction

  function automatic logic [15:0] madd_ref(logic [15:0] u, logic [15:0] s);
    int sum;
    sum = int'(u[7:0]) * int'($signed(s[7:0])) + int'(u[15:8]) * int'($signed(s[15:8]));
    if (sum > 32767) sum = 32767;
    if (sum < -32768) sum = -32768;
    return sum[15:0];
  endfunction

  function automatic logic [W-1:0] vec_ref(logic op, logic wide, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    r = '0;
    for (int k = 0; k < W / 16; k++) begin
      if (wide || k < W / 32)
        r[k*16 +: 16] = op ? madd_ref(a[k*16 +: 16], b[k*16 +: 16])
                           : frac_ref(a[k*16 +: 16], b[k*16 +: 16]);
    end
    return r;
  endfunction

  function automatic logic [31:0] lcg(logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic rnd_vec(output logic [W-1:0] v);
    for (int i = 0; i < W / 32; i++) begin
      seed = lcg(seed);
      v[i*32 +: 32] = seed;
    end
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_pend();
    if (pend) begin
      check({pend_tag, " valid R1"}, W'(valid_o), W'(1'b1));
      check(pend_tag, res_o, pend_exp);
    end
  endtask

  // one strobe per cycle; the previous strobe's result is checked first
  task automatic step(string tag, logic op, logic wide, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk_i);
    check_pend();
    valid_i = 1'b1; op_i = op; wide_i = wide; a_i = a; b_i = b;
    pend = 1'b1; pend_exp = vec_ref(op, wide, a, b); pend_tag = tag;
  endtask

  task automatic flush();
    logic [W-1:0] held;
    logic [W-1:0] r;
    @(negedge clk_i);
    check_pend();
    held = pend_exp;
    pend = 1'b0;
    valid_i = 1'b0;
    rnd_vec(r); a_i = r; rnd_vec(r); b_i = r; op_i = ~op_i; wide_i = ~wide_i;
    @(negedge clk_i);
    check("R1 valid idle", W'(valid_o), '0);
    check("R7 hold", res_o, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", W'(valid_o), '0);
    check("R1 reset res", res_o, '0);
    rst_ni = 1'b1;

    // R3 corner lanes
    rnd_vec(a); rnd_vec(b);
    a[15:0] = 16'h8000; b[15:0] = 16'h8000;
    a[31:16] = 16'h4000; b[31:16] = 16'h4000;
    a[47:32] = 16'ha000; b[47:32] = 16'h4000;
    a[63:48] = 16'h8000; b[63:48] = 16'h7fff;
    step("R3 corners", 1'b0, 1'b1, a, b);
    flush();
    @(negedge clk_i);
    check("R3 min square", W'(res_o[15:0]), W'(16'h8000));
    check("R3 half square", W'(res_o[31:16]), W'(16'h2000));
    check("R3 neg product", W'(res_o[47:32]), W'(16'hd000));

    // R2 fractional sweep
    for (int i = 0; i < 128; i++) begin
      for (int j = 0; j < 256; j++) begin
        rnd_vec(a); rnd_vec(b);
        a[15:0] = 16'(i * 517) ^ 16'h8000;
        b[15:0] = 16'(j * 257) ^ 16'(j << 3);
        step("R2 frac", 1'b0, 1'b1, a, b);
      end
    end
    flush();

    // R4 R5 exhaustive byte pair on lane 0, extreme partner product
    for (int u = 0; u < 256; u++) begin
      for (int s = 0; s < 256; s++) begin
        rnd_vec(a); rnd_vec(b);
        a[7:0] = 8'(u); b[7:0] = 8'(s);
        a[15:8] = 8'hff; b[15:8] = s[0] ? 8'h7f : 8'h80;
        step("R4 R5 madd", 1'b1, 1'b1, a, b);
      end
    end
    flush();

    // R5 explicit limits
    a = '0; b = '0;
    a[15:0] = 16'hffff; b[15:0] = 16'h7f7f;
    a[31:16] = 16'hffff; b[31:16] = 16'h8080;
    a[47:32] = 16'h0101; b[47:32] = 16'hff01;
    step("R5 limits", 1'b1, 1'b1, a, b);
    flush();
    @(negedge clk_i);
    check("R5 high clamp", W'(res_o[15:0]), W'(16'h7fff));
    check("R5 low clamp", W'(res_o[31:16]), W'(16'h8000));
    check("R5 passthrough", W'(res_o[47:32]), W'(16'h0000));

    // R6 narrow mode, both operations
    for (int i = 0; i < 400; i++) begin
      rnd_vec(a); rnd_vec(b);
      step("R6 narrow", 1'(i), 1'b0, a, b);
    end
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule